// File: doc/BRIEF.md
# Clock Multiplier Bring-up Sequencer

This block drives the control pins of an analog clock multiplier from a single configuration command. The command carries an input divider ratio, a feedback multiplier and an output divider ratio. When it is accepted, the block first switches the clock select to the bypass reference and holds the multiplier in reset. It presents the new ratios while reset is held, releases reset, and then waits a lock interval before it selects the multiplied clock. The lock interval is computed from the ratios of the command, not taken from a fixed constant.

The whole block runs on the reference clock. The command arrives on a valid/ready handshake. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the sequencer is idle or locked. While it is low, the sender must hold the command steady, and the block neither samples nor acts on it. A command that is not legal is taken and then rejected: the error flag is set and the multiplier stays in bypass and in reset. Every legal command starts a full relock, even while locked.

Top module: `pll_seq_top`

## Requirements
- R1: After reset, `pll_rst`=1, `pll_en`=0, `seq_done`=0, `cmd_err`=0 and `cmd_ready`=1, and the ratio outputs read 1 (input divider), 4 (multiplier) and 2 (output divider).
- R2: Ratio fields are plain binary ratio values. An input divider from 1 to 32, a multiplier from 4 to 32 and an output divider of exactly 2 are legal. For any other accepted value, the cycle after acceptance shows `cmd_err`=1, `pll_en`=0 and `pll_rst`=1, and the ratio outputs keep their previous values.
- R3: `cmd_ready` is low from the cycle after a legal command is accepted until the lock wait ends. A command held valid during that time is not taken, and the ratios and timing of the running bring-up do not change.
- R4: The new ratios appear on the ratio outputs while `pll_rst` is still high. They stay constant until the next accepted command.
- R5: In every bring-up, `pll_rst` stays high for at least ceil(RST_HOLD_PS / REF_PERIOD_PS) consecutive reference cycles before it falls.
- R6: The number of cycles with `pll_rst`=0 and `pll_en`=0 between reset release and enable equals ceil(2000·N/M), where N is the input divider and M is the multiplier.
- R7: `pll_en` and `seq_done` rise together only at the end of the lock wait. They stay high until the next command is accepted.
- R8: When a command is accepted while `pll_en`=1, `pll_en` is 0 in the very next cycle, whether or not the command is legal.
- R9: Acceptance of a legal command clears `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_prediv | input | 6 | Requested input divider ratio |
| cmd_mult | input | 6 | Requested multiplier ratio |
| cmd_postdiv | input | 6 | Requested output divider ratio |
| pll_rst | output | 1 | Reset to the multiplier, active high |
| pll_prediv | output | 6 | Input divider ratio applied |
| pll_mult | output | 6 | Multiplier ratio applied |
| pll_postdiv | output | 6 | Output divider ratio applied |
| pll_en | output | 1 | Clock select: 0 bypass reference, 1 multiplied path |
| seq_done | output | 1 | Bring-up finished and locked path selected |
| cmd_err | output | 1 | Last accepted command was illegal |

## Verification
Some properties are checked on every cycle. The enable drops in the cycle after any acceptance while locked. A rejected command leaves the block in bypass and in reset. The ratio outputs stay still except at the hand-over from the pending register. A reset pulse is never shorter than the hold count, and the enable rises only out of the lock wait. The exact length of the lock wait for particular ratio pairs must be counted by the bench scenarios, which include the rounding-up cases and the longest legal wait. The same holds for the rejection of each illegal field limit and for a command held against back-pressure being taken only after lock.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_BYPASS,
    S_RESET_HOLD,
    S_PROGRAM,
    S_LOCK_WAIT,
    S_ENABLED
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/pll_seq_ratio_chk.sv
module pll_seq_ratio_chk #(
  parameter int RATIO_W  = 6,
  parameter int PRE_MIN  = 1,
  parameter int PRE_MAX  = 32,
  parameter int MULT_MIN = 4,
  parameter int MULT_MAX = 32,
  parameter int POST_REQ = 2
) (
  input  logic [RATIO_W-1:0] pre,
  input  logic [RATIO_W-1:0] mult,
  input  logic [RATIO_W-1:0] post,
  output logic               ok
);
  always_comb begin
    ok = (32'(pre) >= PRE_MIN) && (32'(pre) <= PRE_MAX) &&
         (32'(mult) >= MULT_MIN) && (32'(mult) <= MULT_MAX) &&
         (32'(post) == POST_REQ);
  end
endmodule

// File: rtl/pll_seq_lock_calc.sv
module pll_seq_lock_calc #(
  parameter int RATIO_W   = 6,
  parameter int LOCK_BASE = 2000,
  parameter int CNT_W     = 14
) (
  input  logic [RATIO_W-1:0] pre,
  input  logic [RATIO_W-1:0] mult,
  output logic [CNT_W-1:0]   lock_cycles
);
  logic [31:0] num;
  logic [31:0] den;

  always_comb begin
    den = (mult == '0) ? 32'd1 : 32'(mult);
    num = 32'(LOCK_BASE) * 32'(pre) + den - 32'd1;
    lock_cycles = CNT_W'(num / den);
  end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (dec)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
  import pll_seq_pkg::*;
#(
  parameter int RATIO_W       = 6,
  parameter int PRE_MIN       = 1,
  parameter int PRE_MAX       = 32,
  parameter int MULT_MIN      = 4,
  parameter int MULT_MAX      = 32,
  parameter int POST_REQ      = 2,
  parameter int LOCK_BASE     = 2000,
  parameter int REF_PERIOD_PS = 20000,
  parameter int RST_HOLD_PS   = 1000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [RATIO_W-1:0] cmd_prediv,
  input  logic [RATIO_W-1:0] cmd_mult,
  input  logic [RATIO_W-1:0] cmd_postdiv,
  output logic               pll_rst,
  output logic [RATIO_W-1:0] pll_prediv,
  output logic [RATIO_W-1:0] pll_mult,
  output logic [RATIO_W-1:0] pll_postdiv,
  output logic               pll_en,
  output logic               seq_done,
  output logic               cmd_err
);
  localparam int RST_CYCLES = ceil_div(RST_HOLD_PS, REF_PERIOD_PS);
  localparam int LOCK_MAX   = ceil_div(LOCK_BASE * PRE_MAX, MULT_MIN);
  localparam int CNT_MAX    = (LOCK_MAX > RST_CYCLES) ? LOCK_MAX : RST_CYCLES;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  seq_state_t state_q, state_d;
  logic [RATIO_W-1:0] pend_pre_q, pend_mult_q, pend_post_q;
  logic [RATIO_W-1:0] pre_q, mult_q, post_q;
  logic               err_q;
  logic               cmd_ok, accept;
  logic [CNT_W-1:0]   lock_cycles, tmr_val;
  logic               tmr_load, tmr_dec, tmr_last;

  pll_seq_ratio_chk #(
    .RATIO_W(RATIO_W), .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX),
    .MULT_MIN(MULT_MIN), .MULT_MAX(MULT_MAX), .POST_REQ(POST_REQ)
  ) u_chk (
    .pre(cmd_prediv), .mult(cmd_mult), .post(cmd_postdiv), .ok(cmd_ok)
  );

  pll_seq_lock_calc #(
    .RATIO_W(RATIO_W), .LOCK_BASE(LOCK_BASE), .CNT_W(CNT_W)
  ) u_calc (
    .pre(pre_q), .mult(mult_q), .lock_cycles(lock_cycles)
  );

  pll_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .last(tmr_last)
  );

  assign cmd_ready = (state_q == S_IDLE) || (state_q == S_ENABLED);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(RST_CYCLES);
    tmr_dec  = 1'b0;
    unique case (state_q)
      S_IDLE, S_ENABLED: if (accept) state_d = cmd_ok ? S_BYPASS : S_IDLE;
      S_BYPASS: begin
        tmr_load = 1'b1;
        state_d  = S_RESET_HOLD;
      end
      S_RESET_HOLD: begin
        tmr_dec = 1'b1;
        if (tmr_last) state_d = S_PROGRAM;
      end
      S_PROGRAM: begin
        tmr_load = 1'b1;
        tmr_val  = lock_cycles;
        state_d  = S_LOCK_WAIT;
      end
      S_LOCK_WAIT: begin
        tmr_dec = 1'b1;
        if (tmr_last) state_d = S_ENABLED;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      err_q       <= 1'b0;
      pend_pre_q  <= RATIO_W'(PRE_MIN);
      pend_mult_q <= RATIO_W'(MULT_MIN);
      pend_post_q <= RATIO_W'(POST_REQ);
      pre_q       <= RATIO_W'(PRE_MIN);
      mult_q      <= RATIO_W'(MULT_MIN);
      post_q      <= RATIO_W'(POST_REQ);
    end else begin
      state_q <= state_d;
      if (accept) begin
        err_q <= !cmd_ok;
        if (cmd_ok) begin
          pend_pre_q  <= cmd_prediv;
          pend_mult_q <= cmd_mult;
          pend_post_q <= cmd_postdiv;
        end
      end
      if (state_q == S_BYPASS) begin
        pre_q  <= pend_pre_q;
        mult_q <= pend_mult_q;
        post_q <= pend_post_q;
      end
    end
  end

  assign pll_rst     = (state_q != S_LOCK_WAIT) && (state_q != S_ENABLED);
  assign pll_en      = (state_q == S_ENABLED);
  assign seq_done    = pll_en;
  assign cmd_err     = err_q;
  assign pll_prediv  = pre_q;
  assign pll_mult    = mult_q;
  assign pll_postdiv = post_q;

  // Consecutive-cycle count of the reset pulse, used by the R5 check.
  int unsigned rst_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rst_run_q <= 0;
    else if (pll_rst) rst_run_q <= rst_run_q + 1;
    else              rst_run_q <= 0;
  end

  // R8
  relock_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pll_en) |=> !pll_en);

  // R2
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_ok) |=> (cmd_err && !pll_en && pll_rst));

  // R4
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_BYPASS) |=>
      ($stable(pll_prediv) && $stable(pll_mult) && $stable(pll_postdiv)));

  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_rst && state_d == S_LOCK_WAIT) |-> (rst_run_q + 1 >= RST_CYCLES));

  // R7
  en_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> ($past(state_q) == S_LOCK_WAIT));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && state_q != S_BYPASS) |=> $stable(pend_pre_q));
endmodule

// File: tb/tb_pll_seq_top.sv
module tb_pll_seq_top;
  localparam int PERIOD_PS = 8000;
  localparam int RST_EXP   = (1000000 + PERIOD_PS - 1) / PERIOD_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [5:0] cmd_prediv = '0, cmd_mult = '0, cmd_postdiv = '0;
  logic cmd_ready, pll_rst, pll_en, seq_done, cmd_err;
  logic [5:0] pll_prediv, pll_mult, pll_postdiv;

  int checks = 0;
  int fails = 0;

  always #4ns clk = ~clk;

  pll_seq_top #(.REF_PERIOD_PS(PERIOD_PS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_prediv(cmd_prediv), .cmd_mult(cmd_mult), .cmd_postdiv(cmd_postdiv),
    .pll_rst(pll_rst), .pll_prediv(pll_prediv), .pll_mult(pll_mult),
    .pll_postdiv(pll_postdiv), .pll_en(pll_en), .seq_done(seq_done),
    .cmd_err(cmd_err)
  );

  function automatic int exp_lock(int n, int m);
    return (2000 * n + m - 1) / m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int n, input int m, input int p);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_prediv = 6'(n); cmd_mult = 6'(m); cmd_postdiv = 6'(p);
  endtask

  task automatic send(input int n, input int m, input int p);
    drive(n, m, p);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1ns cmd_valid = 1'b0;
  endtask

  task automatic measure(output int lock_c, output int rst_max, output int pre_rel,
                         output int mult_rel);
    int run = 0;
    lock_c = 0; rst_max = 0; pre_rel = -1; mult_rel = -1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (pll_en) break;
      if (pll_rst) begin
        run++;
        if (run > rst_max) rst_max = run;
      end else begin
        if (lock_c == 0) begin pre_rel = int'(pll_prediv); mult_rel = int'(mult_rel_f()); end
        run = 0;
        lock_c++;
      end
    end
  endtask

  function automatic logic [5:0] mult_rel_f();
    return pll_mult;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(pll_rst && !pll_en && !seq_done && !cmd_err && cmd_ready, "R1 flags",
        {pll_rst, pll_en, seq_done, cmd_err, cmd_ready}, 5'b10001);
    chk(pll_prediv == 1 && pll_mult == 4 && pll_postdiv == 2, "R1 ratios",
        pll_prediv * 100 + pll_mult * 10 + pll_postdiv, 142);
  endtask

  task automatic t_bringup(input int n, input int m, input string tag);
    int lc, rm, pr, mr;
    bool_hold: begin
      bit was_en;
      was_en = pll_en;
      send(n, m, 2);
      if (was_en) chk(!pll_en, {"R8 bypass after accept ", tag}, pll_en, 0);
    end
    chk(!cmd_ready, {"R3 ready low in sequence ", tag}, cmd_ready, 0);
    measure(lc, rm, pr, mr);
    chk(lc == exp_lock(n, m), {"R6 lock wait ", tag}, lc, exp_lock(n, m));
    chk(rm >= RST_EXP, {"R5 reset hold ", tag}, rm, RST_EXP);
    chk(pr == n && mr == m, {"R4 ratios at release ", tag}, pr * 100 + mr, n * 100 + m);
    chk(pll_en && seq_done && !cmd_err, {"R7 enabled R9 err clear ", tag},
        {pll_en, seq_done, cmd_err}, 3'b110);
    repeat (3) @(negedge clk);
    chk(pll_en && seq_done && pll_prediv == 6'(n) && pll_mult == 6'(m),
        {"R7 stays enabled ", tag}, pll_en, 1);
  endtask

  task automatic t_illegal(input int n, input int m, input int p, input string tag);
    int pre_old = int'(pll_prediv);
    int mult_old = int'(pll_mult);
    send(n, m, p);
    @(negedge clk);
    chk(cmd_err && !pll_en && pll_rst, {"R2 reject flags ", tag},
        {cmd_err, pll_en, pll_rst}, 3'b101);
    chk(int'(pll_prediv) == pre_old && int'(pll_mult) == mult_old && pll_postdiv == 2,
        {"R2 ratios kept ", tag}, int'(pll_prediv) * 100 + int'(pll_mult),
        pre_old * 100 + mult_old);
    chk(cmd_ready, {"R3 ready after reject ", tag}, cmd_ready, 1);
  endtask

  task automatic t_backpressure();
    int lc, rm, pr, mr;
    send(2, 25, 2);
    repeat (20) @(negedge clk);
    drive(4, 10, 2);
    #1ns;
    chk(!cmd_ready, "R3 ready low while busy", cmd_ready, 0);
    measure(lc, rm, pr, mr);
    chk(lc == exp_lock(2, 25) && pll_prediv == 2 && pll_mult == 25,
        "R3 held command not taken", lc, exp_lock(2, 25));
    @(posedge clk);
    #1ns cmd_valid = 1'b0;
    chk(!pll_en, "R8 bypass after held accept", pll_en, 0);
    measure(lc, rm, pr, mr);
    chk(lc == exp_lock(4, 10) && pr == 4 && mr == 10, "R6 held command lock",
        lc, exp_lock(4, 10));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1ns rst_n = 1'b1;
    t_reset();
    t_illegal(0, 20, 2, "prediv 0");
    t_bringup(1, 20, "1x20");
    t_bringup(3, 7, "3x7 ceil");
    t_bringup(1, 32, "1x32 ceil");
    t_illegal(33, 20, 2, "prediv 33");
    t_illegal(1, 3, 2, "mult 3");
    t_illegal(1, 33, 2, "mult 33");
    t_illegal(1, 20, 1, "post 1");
    t_bringup(32, 4, "32x4 longest");
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule